// File: doc/BRIEF.md
# Periodic Tick Rate Divider

This block turns a time-base strobe into two slower event streams for a real-time clock: a programmable periodic tick and a once-per-second update tick. A strobe pulse marks one cycle of the oscillator. A small prescaler first brings the two fast crystal bases down to a common 32768 Hz tick stream. A 15-stage binary chain then divides that stream. The periodic tick is taken from the chain stage that the 4-bit rate code selects. The once-per-second tick comes from the top stage.

The 3-bit base code sets the prescaler ratio. Two of its values instead keep the prescaler, the chain and both outputs cleared. When a hold ends, the whole chain restarts from zero, so the first second tick arrives half a second later. Flag latching, interrupt enables and the calendar counter sit downstream and are outside this block.

Top module: `rtc_rate_divider`

## Requirements
- R1: Rate code 0 produces no periodic tick.
- R2: With the 32 kHz base (base code 2), rate code r in 3..15 gives a tick rate of 65536/2^r Hz. Code 3 gives 8192 Hz and code 15 gives 2 Hz, both measured in 32768 Hz base ticks. The first tick comes half a period after the chain starts.
- R3: With base codes 2..5, rate codes 1 and 2 give 256 Hz and 128 Hz.
- R4: With base codes 0 and 1, rate codes 1 and 2 give 32768 Hz (every base tick) and 16384 Hz.
- R5: Base code 0 divides the strobe by PRE_4M and base code 1 divides it by PRE_1M to form base ticks. Codes 2..5 use every strobe as a base tick.
- R6: While base code 6 or 7 is applied, the prescaler and the chain are cleared, and neither output pulses from the next cycle on.
- R7: The second tick pulses 16384 base ticks after release from hold or reset, and every 32768 base ticks after that. Its pulses are never on adjacent cycles.
- R8: A periodic tick is a one-cycle pulse. It appears two clock edges after the strobe that completes the base tick on which the selected stage rises.
- R9: Base codes 3, 4 and 5 behave as the 32 kHz base.
- R10: Only cycles with the strobe high advance the divider. Gaps in the strobe delay the ticks by exactly the gap length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_stb | input | 1 | One pulse per oscillator time-base cycle |
| div_sel | input | 3 | Base code: 0 fast, 1 medium, 2..5 32 kHz, 6/7 hold |
| rate_sel | input | 4 | Periodic rate code, 0 = off |
| per_tick | output | 1 | Periodic tick pulse |
| sec_tick | output | 1 | Once-per-second update pulse |

## Verification
The bench builds the block with PRE_4M = 4 and PRE_1M = 2 in place of the large crystal ratios. This makes both prescaled bases reachable within a few dozen cycles, so the every-base-tick and 16384 Hz modes can be timed pulse by pulse. The chain keeps its full 15 stages. One long run therefore reaches the 2 Hz stage and two second ticks, including the half-second first one. Sparse strobe patterns combined with the small ratios check that only strobe cycles advance the divider.

// File: rtl/rtc_pdiv_pkg.sv
package rtc_pdiv_pkg;
  // stages in the binary divider after the prescaler
  localparam int CHAIN_W = 15;
  // width of a tap index: 0 off, 1 every base tick, k+2 stage k
  localparam int TAP_W   = 5;
  localparam int DIV_W   = 3;
  localparam int RATE_W  = 4;

  // base codes 6 and 7 keep the divider cleared
  function automatic logic is_hold(input logic [DIV_W-1:0] d);
    return d[2] & d[1];
  endfunction

  // base codes 2..5 run straight from the 32 kHz strobe
  function automatic logic is_slow_base(input logic [DIV_W-1:0] d);
    return d[2:1] != 2'b00;
  endfunction

  // maps rate code to the chain stage whose rising edge is the tick
  function automatic logic [TAP_W-1:0] tap_of(input logic [RATE_W-1:0] r,
                                               input logic slow);
    logic [TAP_W-1:0] t;
    case (r)
      4'd0:    t = '0;
      4'd1:    t = slow ? TAP_W'(8) : TAP_W'(1);
      4'd2:    t = slow ? TAP_W'(9) : TAP_W'(2);
      default: t = TAP_W'(r);
    endcase
    return t;
  endfunction
endpackage

// File: rtl/rtc_pdiv_prescale.sv
module rtc_pdiv_prescale
  import rtc_pdiv_pkg::*;
#(
  parameter int PRE_4M = 128,
  parameter int PRE_1M = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             stb,
  input  logic [DIV_W-1:0] div_sel,
  output logic             base_tick
);
  localparam int CW = $clog2(PRE_4M + 1);
  localparam logic [CW-1:0] LAST_4M = CW'(PRE_4M - 1);
  localparam logic [CW-1:0] LAST_1M = CW'(PRE_1M - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          wrap;

  always_comb begin
    case (div_sel)
      3'd0:    last = LAST_4M;
      3'd1:    last = LAST_1M;
      default: last = '0;
    endcase
  end

  assign wrap = stb && (cnt >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      base_tick <= 1'b0;
    end else if (hold) begin
      cnt       <= '0;
      base_tick <= 1'b0;
    end else begin
      base_tick <= wrap;
      if (wrap)     cnt <= '0;
      else if (stb) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_pdiv_chain.sv
module rtc_pdiv_chain #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         adv,
  output logic [W-1:0] rise
);
  logic [W-1:0] cnt;
  logic [W-1:0] nxt;

  assign nxt = cnt + 1'b1;

  // a stage rises when the increment carries into it
  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_rise
      assign rise[i] = adv & nxt[i] & ~cnt[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (hold) cnt <= '0;
    else if (adv)  cnt <= nxt;
  end
endmodule

// File: rtl/rtc_pdiv_tapsel.sv
module rtc_pdiv_tapsel
  import rtc_pdiv_pkg::*;
#(
  parameter int W = 15
) (
  input  logic [W-1:0]      rise,
  input  logic              adv,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic              slow,
  output logic              per_rise
);
  logic [TAP_W-1:0] tap;
  logic [31:0]      ext;

  assign tap      = tap_of(rate_sel, slow);
  assign ext      = 32'({rise, adv, 1'b0});
  assign per_rise = ext[tap];
endmodule

// File: rtl/rtc_rate_divider.sv
module rtc_rate_divider
  import rtc_pdiv_pkg::*;
#(
  parameter int PRE_4M = 128,
  parameter int PRE_1M = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_stb,
  input  logic [DIV_W-1:0]  div_sel,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              per_tick,
  output logic              sec_tick
);
  logic               hold;
  logic               slow;
  logic               base_tick;
  logic [CHAIN_W-1:0] rise;
  logic               per_rise;

  assign hold = is_hold(div_sel);
  assign slow = is_slow_base(div_sel);

  rtc_pdiv_prescale #(.PRE_4M(PRE_4M), .PRE_1M(PRE_1M)) u_pre (
    .clk(clk), .rst_n(rst_n), .hold(hold), .stb(osc_stb),
    .div_sel(div_sel), .base_tick(base_tick)
  );

  rtc_pdiv_chain #(.W(CHAIN_W)) u_chain (
    .clk(clk), .rst_n(rst_n), .hold(hold), .adv(base_tick), .rise(rise)
  );

  rtc_pdiv_tapsel #(.W(CHAIN_W)) u_tap (
    .rise(rise), .adv(base_tick), .rate_sel(rate_sel), .slow(slow),
    .per_rise(per_rise)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_tick <= 1'b0;
      sec_tick <= 1'b0;
    end else if (hold) begin
      per_tick <= 1'b0;
      sec_tick <= 1'b0;
    end else begin
      per_tick <= per_rise;
      sec_tick <= rise[CHAIN_W-1];
    end
  end
endmodule

// File: rtl/rtc_rate_divider_chk.sv
module rtc_rate_divider_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_stb,
  input logic [3:0] rate_sel,
  input logic       hold,
  input logic       base_tick,
  input logic       per_tick,
  input logic       sec_tick
);
  assert_rate_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 4'd0) |=> !per_tick);

  assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!per_tick && !sec_tick));

  assert_sec_isolated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> !sec_tick);

  assert_sec_on_base_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |-> $past(base_tick));

  assert_tick_after_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
    per_tick |-> $past(base_tick));

  assert_base_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    base_tick |-> $past(osc_stb));
endmodule

bind rtc_rate_divider rtc_rate_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .osc_stb(osc_stb), .rate_sel(rate_sel),
  .hold(hold), .base_tick(base_tick), .per_tick(per_tick),
  .sec_tick(sec_tick)
);

// File: tb/rtc_rate_divider_tb.sv
module rtc_rate_divider_tb;
  localparam int P4 = 4;
  localparam int P1 = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_stb = 1'b0;
  logic [2:0] div_sel = 3'd6;
  logic [3:0] rate_sel = 4'd0;
  logic       per_tick;
  logic       sec_tick;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  string cur_tag = "";
  int    q_per[$];
  int    q_sec[$];

  rtc_rate_divider #(.PRE_4M(P4), .PRE_1M(P1)) u_dut (
    .clk(clk), .rst_n(rst_n), .osc_stb(osc_stb), .div_sel(div_sel),
    .rate_sel(rate_sel), .per_tick(per_tick), .sec_tick(sec_tick)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // tick rate in Hz expected from the requirements, 0 when silent
  function automatic int exp_freq(input int d, input int r);
    if (d >= 6 || r == 0) return 0;
    if (r >= 3) return 65536 >> r;
    return (d >= 2) ? (512 >> r) : (65536 >> r);
  endfunction

  // monitor: compares observed pulses with the queued expectations
  always @(posedge clk) begin
    #1;
    if (mon_on) begin
      if (per_tick) begin
        n_cmp++;
        if (q_per.size() == 0) begin
          n_bad++;
          $display("FAIL %s per_tick: unexpected pulse at cycle %0d, expected none", cur_tag, cyc);
        end else begin
          int e;
          e = q_per.pop_front();
          if (e != cyc) begin
            n_bad++;
            $display("FAIL %s per_tick: pulse at cycle %0d, expected %0d", cur_tag, cyc, e);
          end
        end
      end
      if (sec_tick) begin
        n_cmp++;
        if (q_sec.size() == 0) begin
          n_bad++;
          $display("FAIL %s sec_tick: unexpected pulse at cycle %0d, expected none", cur_tag, cyc);
        end else begin
          int e;
          e = q_sec.pop_front();
          if (e != cyc) begin
            n_bad++;
            $display("FAIL %s sec_tick: pulse at cycle %0d, expected %0d", cur_tag, cyc, e);
          end
        end
      end
    end
  end

  // driver: holds, releases with new codes, queues expected pulse cycles
  task automatic run_case(input int d, input int r, input int s,
                          input int n_edges, input string tag);
    int t0, freq, per, first, pre;
    mon_on = 1'b0;
    div_sel = 3'd6;
    osc_stb = 1'b1;
    repeat (3) @(negedge clk);
    q_per.delete();
    q_sec.delete();
    cur_tag = tag;
    div_sel = 3'(d);
    rate_sel = 4'(r);
    t0 = cyc;
    pre = (d == 0) ? P4 : (d == 1) ? P1 : 1;
    freq = exp_freq(d, r);
    if (freq > 0) begin
      per = 32768 / freq;
      first = (per / 2 > 0) ? per / 2 : 1;
      for (int k = first; (k * pre - 1) * s + 2 <= n_edges; k += per)
        q_per.push_back(t0 + (k * pre - 1) * s + 2);
    end
    if (d < 6)
      for (int k = 16384; (k * pre - 1) * s + 2 <= n_edges; k += 32768)
        q_sec.push_back(t0 + (k * pre - 1) * s + 2);
    mon_on = 1'b1;
    for (int n = 1; n <= n_edges; n++) begin
      osc_stb = ((n - 1) % s == 0);
      @(negedge clk);
    end
    mon_on = 1'b0;
    n_cmp++;
    if (q_per.size() != 0) begin
      n_bad++;
      $display("FAIL %s per_tick: %0d pulses missing, expected 0 missing", tag, q_per.size());
    end
    n_cmp++;
    if (q_sec.size() != 0) begin
      n_bad++;
      $display("FAIL %s sec_tick: %0d pulses missing, expected 0 missing", tag, q_sec.size());
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    n_cmp++;
    if (per_tick !== 1'b0 || sec_tick !== 1'b0) begin
      n_bad++;
      $display("FAIL R6 reset: per=%b sec=%b, expected 0 0", per_tick, sec_tick);
    end
    rst_n = 1'b1;
    @(negedge clk);
    run_case(2, 3, 1, 40,  "R2 8192Hz");
    run_case(2, 7, 1, 300, "R2 512Hz");
    run_case(2, 1, 1, 300, "R3 256Hz");
    run_case(2, 2, 1, 600, "R3 128Hz");
    run_case(0, 1, 1, 40,  "R4 R5 every tick fast base");
    run_case(1, 2, 1, 40,  "R4 R5 16384Hz medium base");
    run_case(0, 0, 1, 100, "R1 rate off");
    run_case(6, 3, 1, 100, "R6 hold code 6");
    run_case(7, 1, 1, 100, "R6 hold code 7");
    run_case(4, 1, 1, 300, "R9 code 4 as slow base");
    run_case(3, 2, 1, 600, "R9 code 3 as slow base");
    run_case(2, 3, 3, 60,  "R10 strobe every third");
    run_case(0, 4, 2, 200, "R5 R10 fast base sparse strobe");
    run_case(2, 1, 1, 5,   "R6 partial run");
    run_case(2, 3, 1, 40,  "R6 restart after hold");
    run_case(2, 15, 1, 50000, "R2 R7 R8 2Hz and second tick");
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run at cycle %0d, expected finish earlier", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule